// File: doc/BRIEF.md
# Interrupt Output Controller

This block merges three event sources (a watchdog timeout, an alarm match and a power-fail detect) onto a single interrupt pin. Each event always records itself in a sticky flag. A per-source enable decides whether that event also makes the pin active. An 8-bit control register selects the pin's electrical style and its timing. The style is active-high push-pull or active-low open-drain. The timing is either a fixed-length pulse or a level that holds until software reads the flags.

The open-drain style is modelled as an output-enable with a data value of 0. When the pin is inactive, the enable is released. Pulse length is counted in ticks of an external divider strobe, and the `PULSE_TICKS` parameter sets the count (default 200 ticks of 1 ms). A flags read clears every flag. In level mode the read also releases the pin. An event that lands in the same cycle as the read wins and sets its flag again.

Top module: `irq_pin_ctrl`

## Requirements
- R1: The control register resets to 0x00. A write stores bit 7 (watchdog enable), bit 6 (alarm enable), bit 5 (power-fail enable), bit 2 (polarity, 1 = active-high push-pull) and bit 1 (1 = pulse, 0 = level). Bits 4, 3 and 0 always read 0.
- R2: Each event sets its own flag in `flags_q` the cycle after it occurs, whatever its enable. Bit 2 is the watchdog flag, bit 1 the alarm flag and bit 0 the power-fail flag.
- R3: An event whose enable bit is 1 makes the pin active. An event whose enable bit is 0 changes only its flag and leaves the pin as it was.
- R4: With polarity 1, `irq_oe` is 1 and `irq_o` equals the active state. With polarity 0, `irq_o` is 0 and `irq_oe` is 1 only while active.
- R5: In level mode the pin becomes active the cycle after an enabled event and stays active until a cycle with `flags_rd` high.
- R6: A cycle with `flags_rd` high clears all flags. An event in that same cycle sets its flag again, and if that event is enabled in level mode the pin stays active.
- R7: In pulse mode an enabled event makes the pin active for exactly `PULSE_TICKS` tick strobes, then inactive. A flags read does not shorten the pulse.
- R8: An enabled event during an active pulse reloads the full count, and the reload takes priority over a tick in the same cycle.
- R9: After reset the pin is inactive (open-drain, released) and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| flags_rd | input | 1 | Flags read strobe; clears flags |
| flags_q | output | 3 | Flags {watchdog, alarm, power-fail} |
| ev_wdog | input | 1 | Watchdog timeout event, one cycle |
| ev_alarm | input | 1 | Alarm match event, one cycle |
| ev_pfail | input | 1 | Power-fail event, one cycle |
| tick | input | 1 | Pulse timebase strobe |
| irq_o | output | 1 | Pin data value |
| irq_oe | output | 1 | Pin output enable |

## Verification
The bench targets the collision of a flags read with an event. A design that let the read win would lose that flag, and in level mode it would drop the pin under a live interrupt. It fires a fresh event partway through a pulse together with a tick. A design lacking the restart, or letting the decrement win, would end the pulse early. It also checks that a read during a pulse leaves the pin active, and that disabled events touch only flags. Across both polarities it watches `irq_oe`, which an open-drain mix-up would leave stuck driven or released.

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl #(
  parameter int PULSE_TICKS = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       flags_rd,
  output logic [2:0] flags_q,
  input  logic       ev_wdog,
  input  logic       ev_alarm,
  input  logic       ev_pfail,
  input  logic       tick,
  output logic       irq_o,
  output logic       irq_oe
);
  localparam int CW = $clog2(PULSE_TICKS + 1);

  logic [2:0]    en_q;
  logic          pol_q, pls_q, lvl_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    ev_vec;
  logic          hit, act;

  assign ev_vec    = {ev_wdog, ev_alarm, ev_pfail};
  assign hit       = |(ev_vec & en_q);
  assign ctl_rdata = {en_q, 2'b00, pol_q, pls_q, 1'b0};
  assign act       = pls_q ? (cnt_q != '0) : lvl_q;
  assign irq_o     = pol_q & act;
  assign irq_oe    = pol_q | act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= 1'b0;
      pls_q <= 1'b0;
    end else if (ctl_we) begin
      en_q  <= ctl_wdata[7:5];
      pol_q <= ctl_wdata[2];
      pls_q <= ctl_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_rd) flags_q <= ev_vec;
    else               flags_q <= flags_q | ev_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lvl_q <= 1'b0;
    else if (hit && !pls_q)    lvl_q <= 1'b1;
    else if (flags_rd)         lvl_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (hit && pls_q)           cnt_q <= CW'(PULSE_TICKS);
    else if (tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // R2
  wdog_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wdog |=> flags_q[2]);

  // R6
  pfail_flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_rd && !ev_pfail) |=> !flags_q[0]);

  // R5
  level_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_rd && !hit) |=> !lvl_q);

  // R8
  pulse_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pls_q) |=> (cnt_q == CW'(PULSE_TICKS)));

  // R7
  pulse_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(1) && tick && !(hit && pls_q)) |=> (cnt_q == '0));
endmodule

// File: tb/sim_irq_pin_ctrl.sv
module sim_irq_pin_ctrl;
  localparam int PT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 0, flags_rd = 0, ev_wdog = 0, ev_alarm = 0, ev_pfail = 0, tick = 0;
  logic [7:0] ctl_wdata = '0, ctl_rdata;
  logic [2:0] flags_q;
  logic irq_o, irq_oe;

  always #5 clk = ~clk;

  irq_pin_ctrl #(.PULSE_TICKS(PT)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .flags_rd(flags_rd), .flags_q(flags_q),
    .ev_wdog(ev_wdog), .ev_alarm(ev_alarm), .ev_pfail(ev_pfail),
    .tick(tick), .irq_o(irq_o), .irq_oe(irq_oe));

  typedef struct {
    logic o, oe;
    logic [2:0] fl;
    logic [7:0] rd;
    string tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0, errors = 0;
  logic [7:0] exp_rd = 8'h00;
  bit done = 0;

  task automatic drive(input logic we, input logic [7:0] wd, input logic rd,
                       input logic [2:0] ev, input logic tk,
                       input logic eo, input logic eoe, input logic [2:0] efl,
                       input string tag);
    item_t it;
    @(negedge clk);
    ctl_we = we; ctl_wdata = wd; flags_rd = rd;
    {ev_wdog, ev_alarm, ev_pfail} = ev; tick = tk;
    if (we) exp_rd = wd & 8'hE6;
    it.o = eo; it.oe = eoe; it.fl = efl; it.rd = exp_rd; it.tag = tag;
    exp_q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        checks++;
        if (irq_o !== it.o || irq_oe !== it.oe || flags_q !== it.fl || ctl_rdata !== it.rd) begin
          errors++;
          $display("FAIL %s: got o=%b oe=%b flags=%b rdata=%h, expected o=%b oe=%b flags=%b rdata=%h",
                   it.tag, irq_o, irq_oe, flags_q, ctl_rdata, it.o, it.oe, it.fl, it.rd);
        end
      end
    end
  end

  initial begin : watchdog
    #200us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(0, 8'h00, 0, 3'b000, 0, 0, 0, 3'b000, "R9");
    drive(1, 8'hFF, 0, 3'b000, 0, 0, 1, 3'b000, "R1");
    drive(1, 8'h84, 0, 3'b000, 0, 0, 1, 3'b000, "R1");
    drive(0, 8'h00, 0, 3'b010, 0, 0, 1, 3'b010, "R3");
    drive(0, 8'h00, 0, 3'b100, 0, 1, 1, 3'b110, "R5");
    drive(0, 8'h00, 0, 3'b000, 0, 1, 1, 3'b110, "R5");
    drive(0, 8'h00, 1, 3'b000, 0, 0, 1, 3'b000, "R5");
    drive(0, 8'h00, 1, 3'b001, 0, 0, 1, 3'b001, "R6");
    drive(0, 8'h00, 1, 3'b100, 0, 1, 1, 3'b100, "R6");
    drive(0, 8'h00, 1, 3'b000, 0, 0, 1, 3'b000, "R6");
    drive(1, 8'h80, 0, 3'b000, 0, 0, 0, 3'b000, "R4");
    drive(0, 8'h00, 0, 3'b100, 0, 0, 1, 3'b100, "R4");
    drive(0, 8'h00, 1, 3'b000, 0, 0, 0, 3'b000, "R4");
    drive(1, 8'h82, 0, 3'b000, 0, 0, 0, 3'b000, "R1");
    drive(0, 8'h00, 0, 3'b100, 0, 0, 1, 3'b100, "R7");
    drive(0, 8'h00, 0, 3'b000, 1, 0, 1, 3'b100, "R7");
    drive(0, 8'h00, 1, 3'b000, 0, 0, 1, 3'b000, "R7");
    drive(0, 8'h00, 0, 3'b000, 1, 0, 1, 3'b000, "R7");
    drive(0, 8'h00, 0, 3'b100, 1, 0, 1, 3'b100, "R8");
    drive(0, 8'h00, 0, 3'b000, 1, 0, 1, 3'b100, "R8");
    drive(0, 8'h00, 0, 3'b000, 1, 0, 1, 3'b100, "R8");
    drive(0, 8'h00, 0, 3'b000, 1, 0, 0, 3'b100, "R8");
    drive(0, 8'h00, 1, 3'b000, 0, 0, 0, 3'b000, "R6");
    drive(1, 8'h1F, 0, 3'b000, 0, 0, 1, 3'b000, "R1");
    drive(0, 8'h00, 0, 3'b111, 0, 0, 1, 3'b111, "R3");
    drive(1, 8'h26, 1, 3'b000, 0, 0, 1, 3'b000, "R6");
    drive(0, 8'h00, 0, 3'b001, 0, 1, 1, 3'b001, "R3");
    drive(0, 8'h00, 0, 3'b000, 1, 1, 1, 3'b001, "R7");
    drive(0, 8'h00, 0, 3'b000, 1, 1, 1, 3'b001, "R7");
    drive(0, 8'h00, 0, 3'b000, 1, 0, 1, 3'b001, "R7");
    drive(1, 8'h44, 0, 3'b000, 0, 0, 1, 3'b001, "R1");
    drive(0, 8'h00, 0, 3'b010, 0, 1, 1, 3'b011, "R3");
    drive(0, 8'h00, 1, 3'b000, 0, 0, 1, 3'b000, "R5");
    drive(0, 8'h00, 0, 3'b000, 0, 0, 1, 3'b000, "R5");
    wait (exp_q.size() == 0);
    @(posedge clk); #3;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule